// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a processor three byte-wide parallel ports, A, B and C, behind a small register bus. The bus has chip select, read and write strobes, a 2-bit register address and an 8-bit data path. A control register sets the direction of four port sections: port A, port B, the upper nibble of port C and the lower nibble of port C. Port A and the upper nibble of C form one 12-line group. Port B and the lower nibble of C form the other.

Pins are modelled as three separate vectors per port: sampled inputs, output values and per-bit output enables. A port section set as output drives its latch and raises its enables. A section set as input drops its enables, and reads of it return the pins.

A control write with the top bit clear is a single-bit command. It sets or clears one chosen port C bit without touching the other port C bits. Only plain unstrobed input/output and this single-bit command are provided.

Top module: `ppi_top`

## Requirements
- R1: After reset all four sections are inputs, every output enable is 0 and every output latch is 0.
- R2: A register write happens only when `cs` and `wr` are both 1 at a rising clock edge; with either low, latches and directions do not change.
- R3: A control write (address 3) with bit 7 = 1 sets directions, where 1 means input: bit 4 sets port A, bit 3 sets upper C, bit 1 sets port B and bit 0 sets lower C. Bits 6, 5 and 2 have no effect.
- R4: A direction-setting control write clears all three output latches to 0.
- R5: A section set as output drives its latch on its output pins with all its enables at 1; a section set as input has its enables at 0.
- R6: The two nibbles of port C follow their own direction bits independently, both for the enables and for reads.
- R7: A control write with bit 7 = 0 writes bit 0 into the port C bit whose index is given by bits 3..1; the other port C bits keep their values.
- R8: With `cs` and `rd` both 1, `rdata` shows the addressed port in the same cycle: pins for input sections and the latch for output sections. Address 3 reads 0, and `rdata` is 0 when no read is active.
- R9: A write to address 0, 1 or 2 loads that port's latch, and the latch appears on the output pins after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register address: 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| paIn | input | 8 | Port A pin values |
| pbIn | input | 8 | Port B pin values |
| pcIn | input | 8 | Port C pin values |
| paOut | output | 8 | Port A output values |
| pbOut | output | 8 | Port B output values |
| pcOut | output | 8 | Port C output values |
| paOe | output | 8 | Port A output enables |
| pbOe | output | 8 | Port B output enables |
| pcOe | output | 8 | Port C output enables |

## Verification
The bench uses the package defaults: 8-bit ports, 4-bit nibbles and a 3-bit bit-select field. With these values it can reach both port C nibbles separately and the highest and lowest single-bit positions. The pin patterns it drives differ from every latch value, so a read that returns the wrong source shows up in the read data.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int SEL_W  = $clog2(DATA_W);
  localparam int ADDR_W = 2;

  // control byte bit positions (software-visible, so fixed)
  localparam int MODE_FLAG_BIT = 7;
  localparam int A_IN_BIT      = 4;
  localparam int CU_IN_BIT     = 3;
  localparam int B_IN_BIT      = 1;
  localparam int CL_IN_BIT     = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_PA   = 2'd0,
    REG_PB   = 2'd1,
    REG_PC   = 2'd2,
    REG_CTRL = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              wrA;
    logic              wrB;
    logic              wrC;
    logic              modeSet;
    logic              bitCmd;
    logic              rdEn;
    regSel_e           rdSel;
    logic [DATA_W-1:0] data;
  } ppiStrobe_t;
endpackage

// File: rtl/ppi_control.sv
module ppi_control
  import ppi_pkg::*;
(
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ppiStrobe_t        strb
);
  logic    wrEn;
  logic    ctrlHit;
  regSel_e sel;

  assign sel     = regSel_e'(addr);
  assign wrEn    = cs && wr;
  assign ctrlHit = wrEn && (sel == REG_CTRL);

  always_comb begin
    strb         = '0;
    strb.wrA     = wrEn && (sel == REG_PA);
    strb.wrB     = wrEn && (sel == REG_PB);
    strb.wrC     = wrEn && (sel == REG_PC);
    strb.modeSet = ctrlHit && wdata[MODE_FLAG_BIT];
    strb.bitCmd  = ctrlHit && !wdata[MODE_FLAG_BIT];
    strb.rdEn    = cs && rd;
    strb.rdSel   = sel;
    strb.data    = wdata;
  end
endmodule

// File: rtl/ppi_datapath.sv
module ppi_datapath
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ppiStrobe_t        strb,
  input  logic [DATA_W-1:0] paIn,
  input  logic [DATA_W-1:0] pbIn,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] paOut,
  output logic [DATA_W-1:0] pbOut,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] paOe,
  output logic [DATA_W-1:0] pbOe,
  output logic [DATA_W-1:0] pcOe,
  output logic [DATA_W-1:0] rdata
);
  // direction flags: 1 = input
  logic              dirA, dirB, dirCu, dirCl;
  logic [DATA_W-1:0] latA, latB, latC;
  logic [SEL_W-1:0]  bitSel;
  logic [DATA_W-1:0] viewA, viewB, viewC;

  assign bitSel = strb.data[SEL_W:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirA  <= 1'b1;
      dirB  <= 1'b1;
      dirCu <= 1'b1;
      dirCl <= 1'b1;
      latA  <= '0;
      latB  <= '0;
      latC  <= '0;
    end else if (strb.modeSet) begin
      dirA  <= strb.data[A_IN_BIT];
      dirB  <= strb.data[B_IN_BIT];
      dirCu <= strb.data[CU_IN_BIT];
      dirCl <= strb.data[CL_IN_BIT];
      latA  <= '0;
      latB  <= '0;
      latC  <= '0;
    end else begin
      if (strb.wrA) latA <= strb.data;
      if (strb.wrB) latB <= strb.data;
      if (strb.wrC) latC <= strb.data;
      if (strb.bitCmd) latC[bitSel] <= strb.data[0];
    end
  end

  assign paOut = latA;
  assign pbOut = latB;
  assign pcOut = latC;
  assign paOe  = {DATA_W{~dirA}};
  assign pbOe  = {DATA_W{~dirB}};
  assign pcOe  = {{HALF_W{~dirCu}}, {HALF_W{~dirCl}}};

  assign viewA = dirA ? paIn : latA;
  assign viewB = dirB ? pbIn : latB;
  assign viewC = {dirCu ? pcIn[DATA_W-1:HALF_W] : latC[DATA_W-1:HALF_W],
                  dirCl ? pcIn[HALF_W-1:0]      : latC[HALF_W-1:0]};

  always_comb begin
    rdata = '0;
    if (strb.rdEn) begin
      unique case (strb.rdSel)
        REG_PA:   rdata = viewA;
        REG_PB:   rdata = viewB;
        REG_PC:   rdata = viewC;
        default:  rdata = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrA || strb.wrB || strb.wrC || strb.modeSet || strb.bitCmd)
    |=> ($stable(latA) && $stable(latB) && $stable(latC) && $stable(paOe)
         && $stable(pbOe) && $stable(pcOe)));

  assert_dir_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeSet |=> (paOe == {DATA_W{~$past(strb.data[A_IN_BIT])}}
                      && pbOe == {DATA_W{~$past(strb.data[B_IN_BIT])}}));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeSet |=> (paOut == '0 && pbOut == '0 && pcOut == '0));

  assert_bit_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bitCmd && !strb.wrC)
    |=> (((pcOut ^ $past(pcOut)) & ~(DATA_W'(1) << $past(bitSel))) == '0));

  assert_port_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrA && !strb.modeSet) |=> (paOut == $past(strb.data)));
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] paIn,
  input  logic [DATA_W-1:0] pbIn,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] paOut,
  output logic [DATA_W-1:0] pbOut,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] paOe,
  output logic [DATA_W-1:0] pbOe,
  output logic [DATA_W-1:0] pcOe
);
  ppiStrobe_t strb;

  ppi_control u_control (
    .cs    (cs),
    .rd    (rd),
    .wr    (wr),
    .addr  (addr),
    .wdata (wdata),
    .strb  (strb)
  );

  ppi_datapath u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .paIn  (paIn),
    .pbIn  (pbIn),
    .pcIn  (pcIn),
    .paOut (paOut),
    .pbOut (pbOut),
    .pcOut (pcOut),
    .paOe  (paOe),
    .pbOe  (pbOe),
    .pcOe  (pcOe),
    .rdata (rdata)
  );
endmodule

// File: tb/ppi_top_bench.sv
`timescale 1ns/1ps
module ppi_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] paIn = 8'h5A, pbIn = 8'hC3, pcIn = 8'hA5;
  logic [7:0] paOut, pbOut, pcOut, paOe, pbOe, pcOe;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  ppi_top u_ppi_top (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .paIn(paIn), .pbIn(pbIn), .pcIn(pcIn),
    .paOut(paOut), .pbOut(pbOut), .pcOut(pcOut),
    .paOe(paOe), .pbOe(pbOe), .pcOe(pcOe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write: strobes held across one rising edge, result visible after it
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d,
                          input logic useCs = 1'b1, input logic useWr = 1'b1);
    @(negedge clk);
    cs = useCs; wr = useWr; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    cs = 1'b0; rd = 1'b0;
    #1;
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 paOe", paOe, 8'h00);
    check("R1 pbOe", pbOe, 8'h00);
    check("R1 pcOe", pcOe, 8'h00);
    check("R1 pcOut", pcOut, 8'h00);
    busRead(2'd0, v);
    check("R8 read input A", v, 8'h5A);
    check("R8 idle rdata", rdata, 8'h00);
  endtask

  task automatic testAllOut();
    logic [7:0] v;
    busWrite(2'd3, 8'h80);
    check("R5 paOe", paOe, 8'hFF);
    check("R5 pcOe", pcOe, 8'hFF);
    busWrite(2'd0, 8'h3C);
    check("R9 paOut", paOut, 8'h3C);
    busRead(2'd0, v);
    check("R8 read output A", v, 8'h3C);
    busWrite(2'd1, 8'h96);
    check("R9 pbOut", pbOut, 8'h96);
    busRead(2'd3, v);
    check("R8 read control", v, 8'h00);
  endtask

  task automatic testNoStrobe();
    busWrite(2'd0, 8'hFF, 1'b0, 1'b1);
    check("R2 no cs", paOut, 8'h3C);
    busWrite(2'd3, 8'h9B, 1'b1, 1'b0);
    check("R2 no wr", paOe, 8'hFF);
    check("R2 no wr latch", pbOut, 8'h96);
  endtask

  task automatic testSplitC();
    logic [7:0] v;
    busWrite(2'd3, 8'h88);
    check("R4 clear A", paOut, 8'h00);
    check("R4 clear B", pbOut, 8'h00);
    check("R6 pcOe upper in", pcOe, 8'h0F);
    busWrite(2'd2, 8'hFF);
    busRead(2'd2, v);
    check("R6 read C mixed", v, 8'hAF);
    busWrite(2'd3, 8'h81);
    check("R6 pcOe lower in", pcOe, 8'hF0);
    busRead(2'd2, v);
    check("R6 read C mixed2", v, 8'h05);
    busWrite(2'd3, 8'h82);
    check("R3 B input", pbOe, 8'h00);
    check("R3 A output", paOe, 8'hFF);
    busRead(2'd1, v);
    check("R8 read input B", v, 8'hC3);
    busWrite(2'd3, 8'h90);
    check("R3 A input", paOe, 8'h00);
    check("R3 B output", pbOe, 8'hFF);
  endtask

  task automatic testIgnoredBits();
    busWrite(2'd3, 8'hE4);
    check("R3 ignored bits A", paOe, 8'hFF);
    check("R3 ignored bits B", pbOe, 8'hFF);
    check("R3 ignored bits C", pcOe, 8'hFF);
  endtask

  task automatic testBitCmd();
    busWrite(2'd2, 8'h00);
    busWrite(2'd3, 8'h0B);   // bit 5 <- 1
    check("R7 set bit5", pcOut, 8'h20);
    busWrite(2'd3, 8'h01);   // bit 0 <- 1
    check("R7 set bit0", pcOut, 8'h21);
    busWrite(2'd3, 8'h0F);   // bit 7 <- 1
    check("R7 set bit7", pcOut, 8'hA1);
    busWrite(2'd3, 8'h0A);   // bit 5 <- 0
    check("R7 clear bit5", pcOut, 8'h81);
    check("R7 dirs kept", pcOe, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllOut();
    testNoStrobe();
    testSplitC();
    testIgnoredBits();
    testBitCmd();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule